// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Programmable Threshold Flags

This block is a first-in first-out queue whose producer and consumer run on separate, unrelated clocks. Next to the usual active-low empty and full indications it has two threshold indications. Almost-empty reports that only a few words remain, and almost-full reports that only a few free slots remain. Each threshold is an offset that software or a controller can change at run time.

The offsets are not loaded through a separate bus. They share the data path. With the configuration select driven LOW, a write strobe stores the low bits of the input word into one of four small offset registers, and a read strobe returns one of them on the output. A selection pointer steps through the four registers in a fixed cycle: empty-offset low part, empty-offset high part, full-offset low part, full-offset high part. The write side and the read side each keep their own pointer. Pointers cross between the clock domains as Gray codes through two-stage synchronizers. The empty-side flags are computed on the read clock and the full-side flags on the write clock.

Top module: `prog_flag_fifo`

## Requirements
- R1: `empty_n` is LOW exactly when 0 words are held, and `full_n` is LOW exactly when DEPTH words are held. Both are registered flags.
- R2: `aempty_n`, updated on `rclk`, is LOW while the word count is n or less and HIGH when it is n+1 or more. n is the empty-offset high register concatenated above the empty-offset low register.
- R3: `afull_n`, updated on `wclk`, is LOW while the word count is DEPTH−m or more and HIGH while more than m slots are free. m is the full-offset high register concatenated above the full-offset low register.
- R4: On a `wclk` rising edge with `cfg_sel_n` LOW and `wr_en_n` LOW, the selected offset register takes `din`. The low registers take `din[LO_W-1:0]` and the high registers take `din[HI_W-1:0]`. LO_W is ceil(log2(DEPTH)/2) and HI_W is log2(DEPTH)−LO_W. Selection indices are 0 for empty low, 1 for empty high, 2 for full low and 3 for full high. The pointer then advances by one.
- R5: On an `rclk` rising edge with `cfg_sel_n` LOW and both read enables LOW, `dout` takes the selected offset register, zero-extended, in the same index order. The read-side pointer then advances, and no queue word is consumed.
- R6: A queue write needs `cfg_sel_n` HIGH and `wr_en_n` LOW. A queue read needs `cfg_sel_n` HIGH and both `rd_en_a_n` and `rd_en_b_n` LOW. `cfg_sel_n` LOW with `wr_en_n` HIGH does nothing, and one read enable alone does nothing.
- R7: After reset, both offsets n and m equal 7.
- R8: A write while full and a read while empty are ignored. The pointers do not move and `dout` keeps its value.
- R9: Words leave in the order they entered, and `dout` is registered on the read edge.
- R10: The active-low asynchronous reset `rst_n` empties the queue: `empty_n` and `aempty_n` are LOW, `full_n` and `afull_n` are HIGH, and `dout` is 0.
- R11: Both selection pointers wrap from index 3 back to index 0, and reset returns them to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| cfg_sel_n | input | 1 | LOW routes strobes to the offset registers |
| wr_en_n | input | 1 | Write strobe, active LOW |
| din | input | DATA_W | Write data or offset value |
| rd_en_a_n | input | 1 | First read enable, active LOW |
| rd_en_b_n | input | 1 | Second read enable, active LOW |
| dout | output | DATA_W | Read data or offset readback |
| empty_n | output | 1 | LOW when no word is held |
| aempty_n | output | 1 | LOW when n or fewer words are held |
| full_n | output | 1 | LOW when DEPTH words are held |
| afull_n | output | 1 | LOW when m or fewer slots are free |

## Verification
Some properties are checked on every edge. A pointer stays put in the cycle after its flag reported full or empty. An offset access never moves a queue pointer. The empty flag never shows while almost-empty is HIGH, and full never shows while almost-full is HIGH. The exact threshold crossings for a loaded n and m, the stepping and wrap of the selection pointers, the default offsets after a reset, and the word order can only be shown by the bench's scenarios. There, a reference model follows each write, read and offset access and predicts every flag.

// File: rtl/pff_pkg.sv
package pff_pkg;

  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // almost-empty is HIGH once the count exceeds the empty offset
  function automatic logic ae_high(input logic [31:0] cnt, input logic [31:0] n);
    return cnt > n;
  endfunction

  // almost-full is HIGH while the free slots exceed the full offset
  function automatic logic af_high(input logic [31:0] cnt, input logic [31:0] m,
                                   input logic [31:0] depth);
    return (cnt + m) < depth;
  endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side
  import pff_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int AW      = 4,
  parameter int LO_W    = 2,
  parameter int HI_W    = 2,
  parameter int DEF_OFS = 7
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              cfg_sel_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] din,
  input  logic [AW:0]       rgray_sync,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [AW:0]       wgray,
  output logic [AW:0]       wbin,
  output logic              full_n,
  output logic              afull_n,
  output logic              wr_fire,
  output logic              cfg_wr_fire,
  output logic [LO_W-1:0]   e_lo,
  output logic [HI_W-1:0]   e_hi,
  output logic [LO_W-1:0]   f_lo,
  output logic [HI_W-1:0]   f_hi
);
  localparam int PW = AW + 1;
  localparam int OW = LO_W + HI_W;
  localparam logic [OW-1:0] DEF = OW'(DEF_OFS);
  localparam logic [31:0] DEPTH32 = 32'(1 << AW);

  logic [PW-1:0] wbin_nx, rbin_s, cnt_nx;
  ofs_sel_e      sel_q;

  assign wr_fire     = cfg_sel_n && !wr_en_n && full_n;
  assign cfg_wr_fire = !cfg_sel_n && !wr_en_n;
  assign wbin_nx     = wbin + PW'(wr_fire);
  assign rbin_s      = PW'(gray_to_bin(32'(rgray_sync)));
  assign cnt_nx      = wbin_nx - rbin_s;
  assign mem_we      = wr_fire;
  assign mem_waddr   = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= PW'(bin_to_gray(32'(wbin_nx)));
      full_n  <= !cnt_nx[AW];
      afull_n <= af_high(32'(cnt_nx), 32'({f_hi, f_lo}), DEPTH32);
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_E_LO;
      e_lo  <= DEF[LO_W-1:0];
      e_hi  <= DEF[OW-1:LO_W];
      f_lo  <= DEF[LO_W-1:0];
      f_hi  <= DEF[OW-1:LO_W];
    end else if (cfg_wr_fire) begin
      sel_q <= ofs_sel_e'(sel_q + 2'd1);
      case (sel_q)
        SEL_E_LO: e_lo <= din[LO_W-1:0];
        SEL_E_HI: e_hi <= din[HI_W-1:0];
        SEL_F_LO: f_lo <= din[LO_W-1:0];
        default:  f_hi <= din[HI_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side
  import pff_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AW     = 4,
  parameter int LO_W   = 2,
  parameter int HI_W   = 2
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              cfg_sel_n,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic [AW:0]       wgray_sync,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [LO_W-1:0]   e_lo,
  input  logic [HI_W-1:0]   e_hi,
  input  logic [LO_W-1:0]   f_lo,
  input  logic [HI_W-1:0]   f_hi,
  output logic [AW-1:0]     mem_raddr,
  output logic [AW:0]       rgray,
  output logic [AW:0]       rbin,
  output logic              empty_n,
  output logic              aempty_n,
  output logic [DATA_W-1:0] dout,
  output logic              rd_fire,
  output logic              cfg_rd_fire
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_nx, wbin_s, cnt_nx;
  logic          both_en;
  ofs_sel_e      sel_q;

  assign both_en     = !rd_en_a_n && !rd_en_b_n;
  assign rd_fire     = cfg_sel_n && both_en && empty_n;
  assign cfg_rd_fire = !cfg_sel_n && both_en;
  assign rbin_nx     = rbin + PW'(rd_fire);
  assign wbin_s      = PW'(gray_to_bin(32'(wgray_sync)));
  assign cnt_nx      = wbin_s - rbin_nx;
  assign mem_raddr   = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= PW'(bin_to_gray(32'(rbin_nx)));
      empty_n  <= (cnt_nx != '0);
      aempty_n <= ae_high(32'(cnt_nx), 32'({e_hi, e_lo}));
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      sel_q <= SEL_E_LO;
    end else if (rd_fire) begin
      dout <= mem_rdata;
    end else if (cfg_rd_fire) begin
      sel_q <= ofs_sel_e'(sel_q + 2'd1);
      case (sel_q)
        SEL_E_LO: dout <= DATA_W'(e_lo);
        SEL_E_HI: dout <= DATA_W'(e_hi);
        SEL_F_LO: dout <= DATA_W'(f_lo);
        default:  dout <= DATA_W'(f_hi);
      endcase
    end
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int DEF_OFS = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              cfg_sel_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LO_W = (AW + 1) / 2;
  localparam int HI_W = AW - LO_W;

  logic [AW:0]       wgray, rgray, wgray_s, rgray_s, wbin, rbin;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] rdata;
  logic              mem_we, wr_fire, rd_fire, cfg_wr_fire, cfg_rd_fire;
  logic [LO_W-1:0]   e_lo, f_lo;
  logic [HI_W-1:0]   e_hi, f_hi;

  pff_wr_side #(.DATA_W(DATA_W), .AW(AW), .LO_W(LO_W), .HI_W(HI_W), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .wr_en_n(wr_en_n), .din(din),
    .rgray_sync(rgray_s), .mem_we(mem_we), .mem_waddr(waddr), .wgray(wgray), .wbin(wbin),
    .full_n(full_n), .afull_n(afull_n), .wr_fire(wr_fire), .cfg_wr_fire(cfg_wr_fire),
    .e_lo(e_lo), .e_hi(e_hi), .f_lo(f_lo), .f_hi(f_hi)
  );

  pff_rd_side #(.DATA_W(DATA_W), .AW(AW), .LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .wgray_sync(wgray_s), .mem_rdata(rdata),
    .e_lo(e_lo), .e_hi(e_hi), .f_lo(f_lo), .f_hi(f_hi), .mem_raddr(raddr),
    .rgray(rgray), .rbin(rbin), .empty_n(empty_n), .aempty_n(aempty_n), .dout(dout),
    .rd_fire(rd_fire), .cfg_rd_fire(cfg_rd_fire)
  );

  pff_sync #(.W(AW + 1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  pff_sync #(.W(AW + 1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  pff_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        full_n,
  input logic        afull_n,
  input logic        empty_n,
  input logic        aempty_n,
  input logic        wr_fire,
  input logic        rd_fire,
  input logic        cfg_wr_fire,
  input logic        cfg_rd_fire,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin
);
  // R8: a full queue keeps its write pointer
  p_no_overflow_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));

  // R8: an empty queue keeps its read pointer
  p_no_underflow_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));

  // R2: empty implies almost-empty
  p_empty_in_ae_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R3: full implies almost-full
  p_full_in_af_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R4: an offset load leaves the write pointer alone
  p_cfg_wr_keeps_ptr_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    cfg_wr_fire |=> $stable(wbin));

  // R5: an offset readback consumes no word
  p_cfg_rd_keeps_ptr_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    cfg_rd_fire |=> $stable(rbin));

  // R6: queue and offset strobes never coincide
  p_wr_excl_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    !(wr_fire && cfg_wr_fire));
  p_rd_excl_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rd_fire && cfg_rd_fire));
endmodule

bind prog_flag_fifo pff_checker #(.AW($clog2(DEPTH))) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full_n(full_n), .afull_n(afull_n),
  .empty_n(empty_n), .aempty_n(aempty_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
  .cfg_wr_fire(cfg_wr_fire), .cfg_rd_fire(cfg_rd_fire), .wbin(wbin), .rbin(rbin)
);

// File: tb/prog_flag_fifo_test.sv
module prog_flag_fifo_test;
  localparam int WP    = 10;
  localparam int RP    = 14;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LO    = (AW + 1) / 2;
  localparam int HI    = AW - LO;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CW = 3'd2,
                         OP_CR = 3'd3, OP_IW = 3'd4, OP_IR = 3'd5;
  localparam int NV = 19;
  // {op, data, expected dout}
  localparam logic [18:0] TBL [NV] = '{
    {OP_CW, 8'h02, 8'h00}, {OP_CW, 8'h00, 8'h00}, {OP_CW, 8'h03, 8'h00}, {OP_CW, 8'h00, 8'h00},
    {OP_CR, 8'h00, 8'h02}, {OP_CR, 8'h00, 8'h00}, {OP_CR, 8'h00, 8'h03}, {OP_CR, 8'h00, 8'h00},
    {OP_WR, 8'h11, 8'h00}, {OP_WR, 8'h22, 8'h00}, {OP_WR, 8'h33, 8'h00}, {OP_WR, 8'h44, 8'h00},
    {OP_RD, 8'h00, 8'h11}, {OP_RD, 8'h00, 8'h22}, {OP_IW, 8'h99, 8'h00}, {OP_CR, 8'h00, 8'h02},
    {OP_IR, 8'h00, 8'h02}, {OP_RD, 8'h00, 8'h33}, {OP_RD, 8'h00, 8'h44}
  };

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic cfg_sel_n = 1, wr_en_n = 1, rd_en_a_n = 1, rd_en_b_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty_n, aempty_n, full_n, afull_n;

  always #(WP/2) wclk = ~wclk;
  always #(RP/2) rclk = ~rclk;

  prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .wr_en_n(wr_en_n),
    .din(din), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .dout(dout),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  int cnt, head, tail, sel_w, sel_r;
  int ofs [4];
  logic [DW-1:0] q [DEPTH];
  logic [DW-1:0] mdout;

  function automatic int fmask(input int idx);
    return (idx % 2 == 0) ? ((1 << LO) - 1) : ((1 << HI) - 1);
  endfunction

  task automatic model_reset();
    cnt = 0; head = 0; tail = 0; sel_w = 0; sel_r = 0; mdout = '0;
    ofs[0] = 7 & fmask(0); ofs[1] = (7 >> LO) & fmask(1);
    ofs[2] = 7 & fmask(2); ofs[3] = (7 >> LO) & fmask(3);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags();
    int n, m;
    n = (ofs[1] << LO) | ofs[0];
    m = (ofs[3] << LO) | ofs[2];
    chk("R1 empty flag", int'(empty_n), int'(cnt != 0));
    chk("R1 full flag", int'(full_n), int'(cnt != DEPTH));
    chk("R2 almost-empty flag", int'(aempty_n), int'(cnt > n));
    chk("R3 almost-full flag", int'(afull_n), int'(cnt + m < DEPTH));
  endtask

  task automatic drive(input logic [2:0] op, input logic [DW-1:0] data);
    if (op == OP_WR || op == OP_CW || op == OP_IW) begin
      @(negedge wclk);
      cfg_sel_n = (op == OP_WR);
      wr_en_n   = (op == OP_IW);
      din       = data;
      @(negedge wclk);
      wr_en_n = 1; cfg_sel_n = 1;
    end else begin
      @(negedge rclk);
      cfg_sel_n = (op != OP_CR);
      rd_en_a_n = 0;
      rd_en_b_n = (op == OP_IR);
      @(negedge rclk);
      rd_en_a_n = 1; rd_en_b_n = 1; cfg_sel_n = 1;
    end
    case (op)
      OP_WR: if (cnt < DEPTH) begin q[tail] = data; tail = (tail + 1) % DEPTH; cnt++; end
      OP_RD: if (cnt > 0) begin mdout = q[head]; head = (head + 1) % DEPTH; cnt--; end
      OP_CW: begin ofs[sel_w] = int'(data) & fmask(sel_w); sel_w = (sel_w + 1) % 4; end
      OP_CR: begin mdout = DW'(ofs[sel_r]); sel_r = (sel_r + 1) % 4; end
      default: ;
    endcase
    repeat (6) @(negedge rclk);
  endtask

  task automatic apply_reset();
    @(negedge wclk);
    rst_n = 0;
    #(2*WP);
    rst_n = 1;
    model_reset();
    repeat (4) @(negedge rclk);
  endtask

  initial begin
    #(WP*100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    #(3*WP);
    rst_n = 1;
    repeat (4) @(negedge rclk);

    // R10: reset state
    chk("R10 empty_n after reset", int'(empty_n), 0);
    chk("R10 aempty_n after reset", int'(aempty_n), 0);
    chk("R10 full_n after reset", int'(full_n), 1);
    chk("R10 afull_n after reset", int'(afull_n), 1);
    chk("R10 dout after reset", int'(dout), 0);

    // R7: default offsets read back as n=7, m=7
    for (int k = 0; k < 4; k++) begin
      drive(OP_CR, 8'h00);
      chk("R7 default offset readback", int'(dout), int'(mdout));
    end

    // table walk: R4 load, R5 readback, R6 no-ops, R9 order
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] dat, exp;
      {op, dat, exp} = TBL[i];
      drive(op, dat);
      if (op == OP_RD)      chk("R9 read data", int'(dout), int'(exp));
      else if (op == OP_CR) chk("R5 R4 offset readback", int'(dout), int'(exp));
      else if (op == OP_IR) chk("R6 single enable keeps dout", int'(dout), int'(exp));
      chk_flags();
    end

    // fill to full with n=2, m=3: R1 R2 R3 crossings
    for (int k = 0; k < DEPTH; k++) begin
      drive(OP_WR, 8'h40 + 8'(k));
      chk_flags();
    end
    // R8: write at full ignored
    drive(OP_WR, 8'hEE);
    chk("R8 count held at full", int'(full_n), 0);
    chk_flags();
    // drain, R9 order
    for (int k = 0; k < DEPTH; k++) begin
      drive(OP_RD, 8'h00);
      chk("R9 drain order", int'(dout), 'h40 + k);
      chk_flags();
    end
    // R8: read at empty ignored
    drive(OP_RD, 8'h00);
    chk("R8 dout held at empty", int'(dout), 'h4F);
    chk_flags();

    // R11: fifth load wraps to the empty low register
    drive(OP_CW, 8'h01); drive(OP_CW, 8'h00); drive(OP_CW, 8'h01);
    drive(OP_CW, 8'h00); drive(OP_CW, 8'h03);
    for (int k = 0; k < 4; k++) begin
      drive(OP_CR, 8'h00);
      chk("R11 wrapped load readback", int'(dout), int'(mdout));
    end
    for (int k = 0; k < 5; k++) begin
      drive(OP_WR, 8'h80 + 8'(k));
      chk_flags();
    end

    // R10 R11: reset mid-run, pointers misaligned before it
    drive(OP_CR, 8'h00);
    drive(OP_CW, 8'h02);
    apply_reset();
    chk("R10 empty_n after mid reset", int'(empty_n), 0);
    chk("R10 aempty_n after mid reset", int'(aempty_n), 0);
    chk("R10 full_n after mid reset", int'(full_n), 1);
    chk("R10 afull_n after mid reset", int'(afull_n), 1);
    for (int k = 0; k < 4; k++) begin
      drive(OP_CR, 8'h00);
      chk("R11 R7 readback pointer restarts", int'(dout), int'(mdout));
    end
    // R7: default n=7 threshold crossing
    for (int k = 0; k < 9; k++) begin
      drive(OP_WR, 8'h20 + 8'(k));
      chk_flags();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule